// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block runs a 64-word by 16-bit serial EEPROM over four lines: a chip select, a serial clock, a data line into the memory and a data line back from it. The host hands over one request at a time with a valid/ready handshake. A request carries an operation code, a word address and 16 bits of write data. The block shifts the command frame out, collects the read word or waits out the memory's internal write cycle, and pulses `done` for one cycle when it returns to idle.

The serial clock is made from the system clock by a divider. Each serial half-period lasts `CLK_DIV` system clocks, and every serial output changes only on a divider tick. Data toward the memory changes while the serial clock is low and is taken by the memory on the rising edge. The returning data line passes through a two-flop synchroniser. After a write, the block checks the memory's busy status on that line with a bounded number of polls. If the line never shows ready, the block reports a timeout.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Operation code 0 is a read. With chip select high, the block sends the bits 1,1,0 and then the 6 address bits MSB first. It then takes 16 bits from the memory, the first one received being bit 15. `rd_data` shows the word when `done` pulses.
- R2: Operation code 1 is a write. With chip select high, the block sends the bits 1,0,1, then the 6 address bits MSB first, then the 16 data bits MSB first: 25 serial clocks in all.
- R3: Operation codes 2 and 3 are write-enable. The block sends the nine bits 1,0,0,1,1,0,0,0,0 with chip select high. It then drops chip select and gives exactly one serial clock pulse with chip select low.
- R4: The data line toward the memory changes only while the serial clock is low.
- R5: Serial outputs change only on divider ticks, so every high phase of the serial clock lasts exactly `CLK_DIV` system clocks.
- R6: At the end of a read, the serial clock goes low while chip select stays high for one half-period (`CLK_DIV` clocks). Only then does chip select fall.
- R7: When a write frame ends, chip select falls and exactly one serial clock pulse is given with chip select low. Chip select is then raised again. The returning line is checked once per serial clock pulse until it reads 1, and the block completes with `timeout` low.
- R8: If the returning line still reads 0 after 100 status checks (99 status clock pulses), the block completes with `timeout` high. Chip select and the serial clock are then both low.
- R9: `req_ready` is high only when the block is idle. A `req_valid` raised while the block is busy has no effect. `done` is high for exactly one cycle per operation.
- R10: After reset, chip select, the serial clock and the outgoing data line are low, `req_ready` is high, and `done`, `timeout` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 write-enable |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to write |
| rd_data | output | 16 | Word from the last read |
| done | output | 1 | One-cycle pulse when an operation completes |
| timeout | output | 1 | Last write never saw ready; valid with `done`, cleared when the next request is taken |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions check, on every cycle, the properties that hold at all times. Serial outputs stay still between divider ticks. The outgoing data line never moves while the serial clock is high. `done` lasts a single cycle. `req_ready` drops once a request is taken, and the serial lines stay low while the block is idle. A rising `timeout` always comes with `done`. The bench's memory model is needed for the rest: the exact bit order of each frame, the read word assembled from the returning line, the single pulse with chip select low, and the number of status polls before ready or timeout. Those scenarios also show that a write without a prior write-enable leaves the memory unchanged, and that a request raised while the block is busy starts no frame.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int MW_ADDR_W = 6;
    localparam int MW_DATA_W = 16;

    localparam logic [2:0] HEAD_READ  = 3'b110;
    localparam logic [2:0] HEAD_WRITE = 3'b101;
    localparam logic [4:0] HEAD_WREN  = 5'b10011;

    typedef enum logic [1:0] {
        KIND_READ,
        KIND_WRITE,
        KIND_WREN
    } mw_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_TX,
        ST_RX,
        ST_RTAIL,
        ST_GAP,
        ST_PCS,
        ST_POLL,
        ST_FIN
    } mw_state_e;

    function automatic mw_kind_e op_to_kind(input logic [1:0] op);
        case (op)
            2'd0:    return KIND_READ;
            2'd1:    return KIND_WRITE;
            default: return KIND_WREN;
        endcase
    endfunction

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
#(
    parameter int ADDR_W     = MW_ADDR_W,
    parameter int DATA_W     = MW_DATA_W,
    parameter int POLL_LIMIT = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              do_s,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              timeout
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

    mw_state_e          state;
    mw_kind_e           kind;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   nbits;
    logic [CNT_W-1:0]   bitcnt;
    logic               phase;
    logic [POLL_W-1:0]  pollcnt;
    logic [DATA_W-1:0]  rx;
    logic               tmo;

    mw_kind_e           kind_n;
    logic [FRAME_W-1:0] frame_n;
    logic [CNT_W-1:0]   nbits_n;

    // frame image, left aligned, for the request on the port
    always_comb begin
        kind_n = op_to_kind(req_op);
        case (kind_n)
            KIND_READ: begin
                frame_n = {HEAD_READ, req_addr, {DATA_W{1'b0}}};
                nbits_n = CNT_W'(CMD_W);
            end
            KIND_WRITE: begin
                frame_n = {HEAD_WRITE, req_addr, req_wdata};
                nbits_n = CNT_W'(FRAME_W);
            end
            default: begin
                frame_n = {HEAD_WREN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
                nbits_n = CNT_W'(CMD_W);
            end
        endcase
    end

    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= KIND_READ;
            shreg   <= '0;
            nbits   <= '0;
            bitcnt  <= '0;
            phase   <= 1'b0;
            pollcnt <= '0;
            rx      <= '0;
            tmo     <= 1'b0;
            cs      <= 1'b0;
            sk      <= 1'b0;
            di      <= 1'b0;
            rd_data <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind    <= kind_n;
                        shreg   <= frame_n;
                        nbits   <= nbits_n;
                        bitcnt  <= '0;
                        phase   <= 1'b0;
                        tmo     <= 1'b0;
                        timeout <= 1'b0;
                        state   <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (tick) begin
                        cs    <= 1'b1;
                        sk    <= 1'b0;
                        di    <= 1'b0;
                        state <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (tick) begin
                        if (!phase) begin
                            di    <= shreg[FRAME_W-1];
                            sk    <= 1'b0;
                            phase <= 1'b1;
                        end else begin
                            sk    <= 1'b1;
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                            phase <= 1'b0;
                            if (bitcnt == nbits - 1'b1) begin
                                bitcnt <= '0;
                                state  <= (kind == KIND_READ) ? ST_RX : ST_GAP;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                ST_RX: begin
                    if (tick) begin
                        if (!phase) begin
                            sk    <= 1'b0;
                            di    <= 1'b0;
                            phase <= 1'b1;
                        end else begin
                            // sample while the clock is still low, then raise it
                            rx    <= {rx[DATA_W-2:0], do_s};
                            sk    <= 1'b1;
                            phase <= 1'b0;
                            if (bitcnt == CNT_W'(DATA_W - 1)) begin
                                bitcnt <= '0;
                                state  <= ST_RTAIL;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                ST_RTAIL: begin
                    if (tick) begin
                        sk    <= 1'b0;
                        state <= ST_FIN;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        bitcnt <= bitcnt + 1'b1;
                        case (bitcnt)
                            CNT_W'(0): begin
                                cs <= 1'b0;
                                sk <= 1'b0;
                                di <= 1'b0;
                            end
                            CNT_W'(1): sk <= 1'b1;
                            default: begin
                                sk     <= 1'b0;
                                bitcnt <= '0;
                                state  <= (kind == KIND_WREN) ? ST_FIN : ST_PCS;
                            end
                        endcase
                    end
                end
                ST_PCS: begin
                    if (tick) begin
                        cs      <= 1'b1;
                        pollcnt <= '0;
                        phase   <= 1'b0;
                        state   <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (tick) begin
                        if (!phase) begin
                            if (do_s) begin
                                state <= ST_FIN;
                            end else if (pollcnt == POLL_W'(POLL_LIMIT - 1)) begin
                                tmo   <= 1'b1;
                                state <= ST_FIN;
                            end else begin
                                sk      <= 1'b1;
                                pollcnt <= pollcnt + 1'b1;
                                phase   <= 1'b1;
                            end
                        end else begin
                            sk    <= 1'b0;
                            phase <= 1'b0;
                        end
                    end
                end
                ST_FIN: begin
                    if (tick) begin
                        cs      <= 1'b0;
                        sk      <= 1'b0;
                        di      <= 1'b0;
                        done    <= 1'b1;
                        timeout <= tmo;
                        if (kind == KIND_READ) begin
                            rd_data <= rx;
                        end
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int ADDR_W      = MW_ADDR_W,
    parameter int DATA_W      = MW_DATA_W,
    parameter int POLL_LIMIT  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              timeout,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic tick_w;
    logic do_s;

    mw_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w)
    );

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_do),
        .q   (do_s)
    );

    mw_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_w),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .do_s      (do_s),
        .cs        (ee_cs),
        .sk        (ee_sk),
        .di        (ee_di),
        .rd_data   (rd_data),
        .done      (done),
        .timeout   (timeout)
    );
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic timeout,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    // R5: serial lines hold still between divider ticks
    a_r5_lines_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(ee_sk) && $stable(ee_cs) && $stable(ee_di)));

    // R4: outgoing data moves only with the serial clock low
    a_r4_di_while_sk_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(ee_di) |-> !ee_sk);

    // R9: completion strobe is a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: taking a request leaves the idle state
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9: idle means chip select and serial clock are low
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ee_cs && !ee_sk));

    // R8: the timeout flag appears only together with completion
    a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> done);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .timeout   (timeout),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/sim_mw_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_mw_eeprom_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [5:0]  req_addr = 6'd0;
    logic [15:0] req_wdata = 16'd0;
    logic [15:0] rd_data;
    logic        done;
    logic        timeout;
    logic        ee_cs, ee_sk, ee_di, ee_do;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_ctrl #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .done(done), .timeout(timeout),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'h5A00 ^ (16'(i) * 16'h0107);
    endfunction

    // ---------------- memory model (single process) ----------------
    logic [15:0] mem [64];
    logic        sk_q = 1'b0, cs_q = 1'b0;
    logic [31:0] fr = '0;
    int          cnt = 0;
    logic        reading = 1'b0, status = 1'b0, wren = 1'b0, dout = 1'b1;
    logic [5:0]  raddr = '0;
    int          ridx = 0;
    int          busy = 0;
    int          busy_init = 5;
    logic        wren_kill = 1'b0;
    int          frames_total = 0, gap_total = 0, poll_total = 0, last_len = 0;
    logic [31:0] last_bits = '0;

    assign ee_do = status ? (busy == 0) : (reading ? dout : 1'b1);

    always @(posedge clk) begin
        sk_q <= ee_sk;
        cs_q <= ee_cs;
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
            wren <= 1'b0; status <= 1'b0; reading <= 1'b0; busy <= 0;
            cnt <= 0; fr <= '0;
        end else begin
            if (wren_kill) wren <= 1'b0;
            if (ee_sk && !sk_q) begin
                if (busy > 0) busy <= busy - 1;
                if (!ee_cs) gap_total <= gap_total + 1;
                else if (status) poll_total <= poll_total + 1;
                else begin
                    fr  <= {fr[30:0], ee_di};
                    cnt <= cnt + 1;
                    if (cnt + 1 == 9 && fr[7:6] == 2'b11 && 1'b0 == ee_di ? 1'b0 : 1'b0) begin
                    end
                    if (cnt + 1 == 9 && {fr[7:0], ee_di} ==? 9'b110??????) begin
                        reading <= 1'b1;
                        raddr   <= {fr[4:0], ee_di};
                        dout    <= mem[{fr[4:0], ee_di}][15];
                        ridx    <= 14;
                    end else if (reading && ridx >= 0) begin
                        dout <= mem[raddr][ridx];
                        ridx <= ridx - 1;
                    end
                end
            end
            if (!ee_cs && cs_q) begin
                if (status) begin
                    status <= 1'b0;
                    busy   <= 0;
                end else if (cnt > 0) begin
                    frames_total <= frames_total + 1;
                    last_len     <= cnt;
                    last_bits    <= fr;
                    if (cnt == 9 && fr[8:0] == 9'b100110000) wren <= 1'b1;
                    if (cnt == 25 && fr[24:22] == 3'b101 && wren) begin
                        mem[fr[21:16]] <= fr[15:0];
                        status <= 1'b1;
                        busy   <= busy_init;
                    end
                end
                reading <= 1'b0;
                cnt     <= 0;
                fr      <= '0;
            end
        end
    end

    // ---------------- line monitors ----------------
    int   hi_run = 0, hi_bad = 0, di_bad = 0, low_run = 0, low_at_csfall = 0;
    logic prev_di = 1'b0, prev_cs = 1'b0;
    always @(posedge clk) begin
        prev_di <= ee_di;
        prev_cs <= ee_cs;
        if (ee_sk) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0 && hi_run != DIV) hi_bad <= hi_bad + 1;
            hi_run <= 0;
        end
        if (!rst && ee_di != prev_di && ee_sk) di_bad <= di_bad + 1;
        if (ee_sk) low_run <= 0; else low_run <= low_run + 1;
        if (prev_cs && !ee_cs) low_at_csfall <= low_run;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
    endtask

    task automatic t_reset();
        chk(ee_cs == 0 && ee_sk == 0 && ee_di == 0, "R10 lines low", {ee_cs, ee_sk, ee_di}, 0);
        chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 1);
        chk(done == 0 && timeout == 0, "R10 flags", {done, timeout}, 0);
        chk(rd_data == 16'd0, "R10 rd_data", 32'(rd_data), 0);
    endtask

    task automatic t_read(input logic [5:0] a, input logic [15:0] exp);
        int f0;
        f0 = frames_total;
        do_req(2'd0, a, 16'hFFFF);
        chk(rd_data == exp, "R1 read word", 32'(rd_data), 32'(exp));
        chk(last_len == 25 && last_bits[24:16] == {3'b110, a}, "R1 read header",
            last_bits[24:16], {23'd0, 3'b110, a});
        chk(frames_total == f0 + 1, "R1 one frame", frames_total, f0 + 1);
        chk(low_at_csfall == DIV, "R6 tail before cs fall", low_at_csfall, DIV);
    endtask

    task automatic t_wren(input logic [1:0] op);
        int g0;
        g0 = gap_total;
        do_req(op, 6'd0, 16'd0);
        chk(last_len == 9 && last_bits[8:0] == 9'b100110000, "R3 enable frame",
            last_bits[8:0], 9'b100110000);
        chk(gap_total == g0 + 1, "R3 one pulse with cs low", gap_total - g0, 1);
        chk(wren == 1'b1, "R3 enable accepted", 32'(wren), 1);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] d, input int bz);
        int g0, p0;
        busy_init = bz;
        g0 = gap_total; p0 = poll_total;
        do_req(2'd1, a, d);
        chk(last_len == 25 && last_bits[24:0] == {3'b101, a, d}, "R2 write frame",
            last_bits[24:0], {7'd0, 3'b101, a, d});
        chk(gap_total == g0 + 1, "R7 one pulse with cs low", gap_total - g0, 1);
        chk(poll_total - p0 == bz - 1, "R7 status clocks", poll_total - p0, bz - 1);
        chk(timeout == 1'b0, "R7 no timeout", 32'(timeout), 0);
    endtask

    task automatic t_timeout(input logic [5:0] a, input logic [15:0] d);
        int p0;
        busy_init = 1000;
        p0 = poll_total;
        do_req(2'd1, a, d);
        chk(poll_total - p0 == 99, "R8 polls before giving up", poll_total - p0, 99);
        chk(timeout == 1'b1, "R8 timeout flag", 32'(timeout), 1);
        chk(ee_cs == 0 && ee_sk == 0, "R8 lines low", {ee_cs, ee_sk}, 0);
        busy_init = 5;
    endtask

    task automatic t_busy_ignore(input logic [5:0] a, input logic [15:0] exp);
        int f0;
        f0 = frames_total;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = a; req_wdata = 16'hDEAD;
        repeat (10) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R9 not ready while busy", 32'(req_ready), 0);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(rd_data == exp, "R9 read unaffected", 32'(rd_data), 32'(exp));
        repeat (3 * DIV) @(negedge clk);
        chk(frames_total == f0 + 1, "R9 busy request ignored", frames_total - f0, 1);
        t_read(a, exp);
    endtask

    task automatic t_no_enable(input logic [5:0] a);
        @(negedge clk); wren_kill = 1'b1;
        @(negedge clk); wren_kill = 1'b0;
        do_req(2'd1, a, 16'h1234);
        t_read(a, init_word(a));
    endtask

    // ---------------- sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read(6'd0, init_word(0));
        t_read(6'd63, init_word(63));
        t_no_enable(6'd5);
        t_wren(2'd2);
        t_write(6'd5, 16'h8001, 5);
        t_read(6'd5, 16'h8001);
        t_write(6'd42, 16'h7FFE, 2);
        t_read(6'd42, 16'h7FFE);
        t_timeout(6'd9, 16'hC3A5);
        t_read(6'd9, 16'hC3A5);
        chk(timeout == 1'b0, "R8 flag cleared by next request", 32'(timeout), 0);
        @(negedge clk); wren_kill = 1'b1;
        @(negedge clk); wren_kill = 1'b0;
        t_wren(2'd3);
        t_write(6'd17, 16'h0F0F, 3);
        t_busy_ignore(6'd17, 16'h0F0F);
        chk(hi_bad == 0, "R5 sk high width", hi_bad, 0);
        chk(di_bad == 0, "R4 di stable while sk high", di_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule